// File: doc/BRIEF.md
# Panel Power Sequencer

This block brings an internal flat panel's supply and backlight up and down in a fixed, timed order. Software programs the delays through a small register file and then sets or clears a single target bit. The sequencer then raises panel VDD and waits a programmed power-up time. It waits a further settling time before it allows the backlight. On the way down it removes the backlight first, holds VDD for a programmed time, removes VDD, waits a power-down time, and then enforces a minimum off time before any new power-up may start.

All short delays count in units of a reference tick. The tick is made by dividing the core clock by a programmable reference divider, nominally 100 µs. The minimum off time counts in a coarse unit of `CYC_TICKS` reference ticks, nominally 100 ms. The delay registers can only be changed while an unlock key is held in the control register. A functional reset can be told to leave the panel in a safe, timed-off state.

Top module: `panel_pwr_seq`

## Requirements
- R1: After `hardRst`, `panelVdd` and `backlightEn` are low and the register reads are: address 0 (status) 0, address 1 (control) 0, address 2 (on-timing) 0, address 3 (off-timing) 0, address 4 (divider) `DEF_REF_DIV << 8`. Any unmapped address (5 to 7) reads 0. Reads are combinational from `addr`.
- R2: Setting control bit 0 (target) starts power-up. `panelVdd` rises and status bits 29:28 read 01 for the power-up delay, which is on-timing bits 28:16 times the tick. Status bit 31 (panel enabled) is then set.
- R3: `backlightEn` is high only when control bit 2 is set and the settling delay (on-timing bits 12:0 times the tick) after the power-up delay has completed. Status bits 29:28 stay 01 during the settling delay. Clearing control bit 2 drops `backlightEn` at once.
- R4: Status bits 29:28 encode 00 idle, 01 powering up and 10 powering down. They never read 11, and they return to 00 when a sequence ends.
- R5: Clearing control bit 0 drops `backlightEn` first. VDD stays high for the off-timing bits 12:0 delay and then drops. Status bits 29:28 read 10 through the following power-down delay (off-timing bits 28:16).
- R6: When the power-down delay ends, status bit 27 is set for (F−1)×`CYC_TICKS` ticks, where F is divider bits 4:0. F of 0 or 1 gives no extra wait. While bit 27 is set, VDD stays low even if control bit 0 is set; power-up begins once it clears.
- R7: One tick is R core clocks, where R is divider bits 31:8. R = 0 behaves as R = 1.
- R8: Writes to addresses 2, 3 and 4 take effect only while control bits 31:16 hold 0xABCD, and are otherwise ignored. The control register is always writable.
- R9: A cycle of `rst` forces `panelVdd` and `backlightEn` low at that edge and clears control bits 0, 2 and 3. It keeps the key and bit 1. If control bit 1 was set, the power-cycle wait of R6 is armed (status bit 27 set). Otherwise the sequencer is idle with status 0.
- R10: Control bit 3 raises `panelVdd` while the sequencer is idle and no power-cycle wait is running. Status stays 00 during this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| hardRst | input | 1 | Synchronous power-on reset, clears all registers |
| rst | input | 1 | Synchronous functional reset, honours control bit 1 |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |
| panelVdd | output | 1 | Panel supply enable |
| backlightEn | output | 1 | Backlight enable |

## Verification
The hardest state to reach from the ports is a target request that arrives while the power-cycle wait is running. That wait only exists after a complete up-and-down sequence and lasts thousands of clocks. The bench therefore runs a full sequence with short phase delays and a small coarse-unit field. It spots the rise of status bit 27, sets the target during the wait, and checks that VDD stays low for every remaining cycle and rises right after the wait ends. Phase lengths are swept over several delay values and divider settings, including a divider of zero, and each is compared against arithmetic on the programmed fields.

// File: rtl/pps_pkg.sv
`timescale 1ns/1ps
package pps_pkg;

  localparam int ADDR_W = 3;
  localparam int DLY_W  = 13;
  localparam int REF_W  = 24;
  localparam int CYC_W  = 5;
  localparam logic [15:0] UNLOCK_KEY = 16'hABCD;

  localparam logic [ADDR_W-1:0] A_STATUS = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd1;
  localparam logic [ADDR_W-1:0] A_ONT    = 3'd2;
  localparam logic [ADDR_W-1:0] A_OFFT   = 3'd3;
  localparam logic [ADDR_W-1:0] A_DIV    = 3'd4;

  localparam logic [1:0] PROG_IDLE = 2'b00;
  localparam logic [1:0] PROG_UP   = 2'b01;
  localparam logic [1:0] PROG_DOWN = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CYCLE, ST_PWRUP, ST_SETTLE, ST_ON, ST_BLOFF, ST_PWRDN
  } seq_state_e;

  typedef enum logic [2:0] {
    TM_NONE, TM_PWRUP, TM_SETTLE, TM_BLOFF, TM_PWRDN, TM_CYCLE
  } timer_sel_e;

  typedef struct packed {
    logic       timerStart;
    timer_sel_e timerSel;
  } seq_cmd_t;

  typedef struct packed {
    logic [15:0] key;
    logic        vddOverride;
    logic        blEnable;
    logic        pdor;
    logic        targetOn;
  } ctrl_reg_t;

endpackage

// File: rtl/pps_datapath.sv
`timescale 1ns/1ps
module pps_datapath
  import pps_pkg::*;
#(
  parameter int DEF_REF_DIV = 20000,
  parameter int CYC_TICKS   = 1000,
  parameter int TICK_W      = 16
) (
  input  logic              clk,
  input  logic              hardRst,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  input  logic [31:0]       statusWord,
  input  seq_cmd_t          cmd,
  output logic [31:0]       rdData,
  output logic              timerDone,
  output logic              targetOn,
  output logic              pdor,
  output logic              blEnable,
  output logic              vddOverride
);

  ctrl_reg_t          ctrlReg;
  logic [1:0]         portSel;
  logic [DLY_W-1:0]   pwrUpDly, settleDly, blOffDly, pwrDnDly;
  logic [REF_W-1:0]   refDiv;
  logic [CYC_W-1:0]   cycField;

  logic [REF_W-1:0]   preCnt, divM1;
  logic [TICK_W-1:0]  tickCnt, target;
  logic [31:0]        cycProd;
  logic               tickNow, unlocked;

  assign unlocked = (ctrlReg.key == UNLOCK_KEY);

  // register file
  always_ff @(posedge clk) begin
    if (hardRst) begin
      ctrlReg   <= '0;
      portSel   <= '0;
      pwrUpDly  <= '0;
      settleDly <= '0;
      blOffDly  <= '0;
      pwrDnDly  <= '0;
      refDiv    <= REF_W'(DEF_REF_DIV);
      cycField  <= '0;
    end else if (rst) begin
      ctrlReg.targetOn    <= 1'b0;
      ctrlReg.blEnable    <= 1'b0;
      ctrlReg.vddOverride <= 1'b0;
    end else if (wrEn) begin
      if (addr == A_CTRL)
        ctrlReg <= {wrData[31:16], wrData[3:0]};
      if (unlocked && addr == A_ONT) begin
        portSel   <= wrData[31:30];
        pwrUpDly  <= wrData[28:16];
        settleDly <= wrData[12:0];
      end
      if (unlocked && addr == A_OFFT) begin
        pwrDnDly <= wrData[28:16];
        blOffDly <= wrData[12:0];
      end
      if (unlocked && addr == A_DIV) begin
        refDiv   <= wrData[31:8];
        cycField <= wrData[4:0];
      end
    end
  end

  // reference tick and phase timer
  assign divM1   = (refDiv == '0) ? '0 : refDiv - 1'b1;
  assign tickNow = (preCnt >= divM1);

  always_ff @(posedge clk) begin
    if (hardRst || rst || cmd.timerStart) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (tickNow) begin
      preCnt <= '0;
      if (tickCnt != {TICK_W{1'b1}})
        tickCnt <= tickCnt + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_comb begin
    cycProd = (cycField > 5'd1) ? (32'(cycField) - 32'd1) * 32'(CYC_TICKS) : 32'd0;
    case (cmd.timerSel)
      TM_PWRUP:  target = TICK_W'(pwrUpDly);
      TM_SETTLE: target = TICK_W'(settleDly);
      TM_BLOFF:  target = TICK_W'(blOffDly);
      TM_PWRDN:  target = TICK_W'(pwrDnDly);
      TM_CYCLE:  target = TICK_W'(cycProd);
      default:   target = '0;
    endcase
  end

  assign timerDone = (tickCnt >= target);

  // read mux
  always_comb begin
    case (addr)
      A_STATUS: rdData = statusWord;
      A_CTRL:   rdData = {ctrlReg.key, 12'd0, ctrlReg.vddOverride, ctrlReg.blEnable,
                          ctrlReg.pdor, ctrlReg.targetOn};
      A_ONT:    rdData = {portSel, 1'b0, pwrUpDly, 3'd0, settleDly};
      A_OFFT:   rdData = {3'd0, pwrDnDly, 3'd0, blOffDly};
      A_DIV:    rdData = {refDiv, 3'd0, cycField};
      default:  rdData = '0;
    endcase
  end

  assign targetOn    = ctrlReg.targetOn;
  assign pdor        = ctrlReg.pdor;
  assign blEnable    = ctrlReg.blEnable;
  assign vddOverride = ctrlReg.vddOverride;

endmodule

// File: rtl/pps_ctrl.sv
`timescale 1ns/1ps
module pps_ctrl
  import pps_pkg::*;
(
  input  logic       clk,
  input  logic       hardRst,
  input  logic       rst,
  input  logic       targetOn,
  input  logic       pdor,
  input  logic       blEnable,
  input  logic       vddOverride,
  input  logic       timerDone,
  output seq_cmd_t   cmd,
  output logic       panelVdd,
  output logic       backlightEn,
  output logic       enabled,
  output logic [1:0] progress,
  output logic       cycActive
);

  seq_state_e state, nextState;

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:   if (targetOn) nextState = ST_PWRUP;
      ST_CYCLE:  if (timerDone) nextState = ST_IDLE;
      ST_PWRUP:  if (!targetOn) nextState = ST_BLOFF;
                 else if (timerDone) nextState = ST_SETTLE;
      ST_SETTLE: if (!targetOn) nextState = ST_BLOFF;
                 else if (timerDone) nextState = ST_ON;
      ST_ON:     if (!targetOn) nextState = ST_BLOFF;
      ST_BLOFF:  if (timerDone) nextState = ST_PWRDN;
      ST_PWRDN:  if (timerDone) nextState = ST_CYCLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (hardRst)   state <= ST_IDLE;
    else if (rst)  state <= pdor ? ST_CYCLE : ST_IDLE;
    else           state <= nextState;
  end

  always_comb begin
    cmd.timerStart = (nextState != state);
    case (state)
      ST_PWRUP:  cmd.timerSel = TM_PWRUP;
      ST_SETTLE: cmd.timerSel = TM_SETTLE;
      ST_BLOFF:  cmd.timerSel = TM_BLOFF;
      ST_PWRDN:  cmd.timerSel = TM_PWRDN;
      ST_CYCLE:  cmd.timerSel = TM_CYCLE;
      default:   cmd.timerSel = TM_NONE;
    endcase
  end

  always_comb begin
    panelVdd    = (state == ST_PWRUP) || (state == ST_SETTLE) || (state == ST_ON) ||
                  (state == ST_BLOFF) || ((state == ST_IDLE) && vddOverride);
    backlightEn = (state == ST_ON) && blEnable;
    enabled     = (state == ST_SETTLE) || (state == ST_ON);
    cycActive   = (state == ST_CYCLE);
    case (state)
      ST_PWRUP, ST_SETTLE: progress = PROG_UP;
      ST_BLOFF, ST_PWRDN:  progress = PROG_DOWN;
      default:             progress = PROG_IDLE;
    endcase
  end

endmodule

// File: rtl/panel_pwr_seq.sv
`timescale 1ns/1ps
module panel_pwr_seq
  import pps_pkg::*;
#(
  parameter int DEF_REF_DIV = 20000,
  parameter int CYC_TICKS   = 1000,
  parameter int TICK_W      = 16
) (
  input  logic        clk,
  input  logic        hardRst,
  input  logic        rst,
  input  logic        wrEn,
  input  logic [2:0]  addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        panelVdd,
  output logic        backlightEn
);

  seq_cmd_t   cmd;
  logic       timerDone, targetOn, pdor, blEnable, vddOverride;
  logic       enabled, cycActive;
  logic [1:0] progress;
  logic [31:0] statusWord;

  assign statusWord = {enabled, 1'b0, progress, cycActive, 27'd0};

  pps_datapath #(
    .DEF_REF_DIV(DEF_REF_DIV), .CYC_TICKS(CYC_TICKS), .TICK_W(TICK_W)
  ) u_dp (
    .clk(clk), .hardRst(hardRst), .rst(rst), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .statusWord(statusWord), .cmd(cmd), .rdData(rdData),
    .timerDone(timerDone), .targetOn(targetOn), .pdor(pdor),
    .blEnable(blEnable), .vddOverride(vddOverride)
  );

  pps_ctrl u_ctrl (
    .clk(clk), .hardRst(hardRst), .rst(rst), .targetOn(targetOn), .pdor(pdor),
    .blEnable(blEnable), .vddOverride(vddOverride), .timerDone(timerDone),
    .cmd(cmd), .panelVdd(panelVdd), .backlightEn(backlightEn),
    .enabled(enabled), .progress(progress), .cycActive(cycActive)
  );

endmodule

// File: rtl/panel_pwr_seq_chk.sv
`timescale 1ns/1ps
module panel_pwr_seq_chk (
  input logic       clk,
  input logic       hardRst,
  input logic       rst,
  input logic       panelVdd,
  input logic       backlightEn,
  input logic       blEnable,
  input logic       enabled,
  input logic [1:0] progress,
  input logic       cycActive
);

  logic rstD = 1'b1;
  always_ff @(posedge clk) rstD <= rst || hardRst;

  a_r2_enable_after_up: assert property (@(posedge clk)
    disable iff (hardRst || rst || rstD)
    $rose(enabled) |-> ($past(progress) == 2'b01));

  a_r3_bl_gated: assert property (@(posedge clk)
    disable iff (hardRst || rst)
    backlightEn |-> (panelVdd && blEnable && enabled));

  a_r4_progress_legal: assert property (@(posedge clk)
    disable iff (hardRst || rst)
    progress != 2'b11);

  a_r5_bl_before_vdd: assert property (@(posedge clk)
    disable iff (hardRst || rst || rstD)
    $fell(panelVdd) |-> !$past(backlightEn));

  a_r6_no_vdd_in_cycle: assert property (@(posedge clk)
    disable iff (hardRst || rst)
    cycActive |-> !panelVdd);

  a_r9_reset_drops: assert property (@(posedge clk)
    disable iff (hardRst)
    rst |=> (!panelVdd && !backlightEn));

endmodule

bind panel_pwr_seq panel_pwr_seq_chk u_chk (
  .clk(clk), .hardRst(hardRst), .rst(rst), .panelVdd(panelVdd),
  .backlightEn(backlightEn), .blEnable(blEnable), .enabled(enabled),
  .progress(progress), .cycActive(cycActive)
);

// File: tb/panel_pwr_seq_tb.sv
`timescale 1ns/1ps
module panel_pwr_seq_tb;

  localparam int DEFDIV = 3;
  localparam int CYCT   = 1000;
  localparam logic [31:0] KEY  = 32'hABCD_0000;
  localparam logic [31:0] TGT  = 32'h1;
  localparam logic [31:0] PDR  = 32'h2;
  localparam logic [31:0] BLEN = 32'h4;
  localparam logic [31:0] OVR  = 32'h8;
  localparam logic [31:0] M_EN = 32'h8000_0000;
  localparam logic [31:0] M_PR = 32'h3000_0000;
  localparam logic [31:0] M_CY = 32'h0800_0000;

  logic clk = 1'b0;
  logic hardRst = 1'b1, rst = 1'b0, wrEn = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic panelVdd, backlightEn;

  int errs = 0, checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  panel_pwr_seq #(.DEF_REF_DIV(DEFDIV), .CYC_TICKS(CYCT), .TICK_W(16)) u_dut (
    .clk(clk), .hardRst(hardRst), .rst(rst), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .panelVdd(panelVdd), .backlightEn(backlightEn)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkRange(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // count negedges until (status & mask) == val
  task automatic waitStat(input logic [31:0] mask, input logic [31:0] val, output int n);
    logic [31:0] st;
    n = 0;
    forever begin
      rd(3'd0, st);
      if ((st & mask) == val) break;
      n++;
      if (n >= 20000) break;
      @(negedge clk);
    end
  endtask

  task automatic powerUp(input logic [31:0] bits);
    int n;
    wr(3'd1, KEY | bits | TGT);
    waitStat(M_EN | M_PR, M_EN, n);
  endtask

  task automatic powerDown(input logic [31:0] bits);
    int n;
    wr(3'd1, KEY | bits);
    @(negedge clk);
    waitStat(M_PR | M_CY, 32'h0, n);
  endtask

  task automatic pulseRst();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    #(150000 * 5);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk);
    hardRst = 1'b0;
    @(negedge clk);

    // R1 reset state and address map
    chk("R1 vdd", {31'd0, panelVdd}, 32'd0);
    chk("R1 bl", {31'd0, backlightEn}, 32'd0);
    rd(3'd0, d); chk("R1 status", d, 32'd0);
    rd(3'd1, d); chk("R1 control", d, 32'd0);
    rd(3'd2, d); chk("R1 on-timing", d, 32'd0);
    rd(3'd3, d); chk("R1 off-timing", d, 32'd0);
    rd(3'd4, d); chk("R1 divider", d, 32'(DEFDIV) << 8);
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), d); chk("R1 unmapped", d, 32'd0);
    end

    // R8 write protection
    wr(3'd2, 32'h4005_0002);
    rd(3'd2, d); chk("R8 locked on-timing", d, 32'd0);
    wr(3'd4, 32'h0000_0705);
    rd(3'd4, d); chk("R8 locked divider", d, 32'(DEFDIV) << 8);
    wr(3'd1, KEY);
    rd(3'd1, d); chk("R8 control writable", d, KEY);
    wr(3'd2, 32'h4005_0002);
    rd(3'd2, d); chk("R8 unlocked on-timing", d, 32'h4005_0002);
    wr(3'd1, 32'h1234_0000);
    rd(3'd1, d); chk("R8 control wrong key", d, 32'h1234_0000);
    wr(3'd3, 32'h0003_0003);
    rd(3'd3, d); chk("R8 relocked off-timing", d, 32'd0);
    wr(3'd1, KEY);

    // R2 R3 R4 R5 R7 sweep of phase lengths
    for (int di = 0; di < 3; di++) begin
      for (int pu = 0; pu < 2; pu++) begin
        for (int bo = 0; bo < 2; bo++) begin
          int divv, eff, puv, stv, bov, pdv, e;
          logic [31:0] bl;
          divv = (di == 0) ? 0 : (di == 1) ? 1 : 3;
          eff  = (divv == 0) ? 1 : divv;
          puv  = pu * 3;
          stv  = bo * 2 + 1;
          bov  = bo * 2;
          pdv  = 4 - bo * 2;
          bl   = (di != 1) ? BLEN : 32'd0;
          wr(3'd2, (32'(puv) << 16) | 32'(stv));
          wr(3'd3, (32'(pdv) << 16) | 32'(bov));
          wr(3'd4, 32'(divv) << 8);
          wr(3'd1, KEY | bl | TGT);
          waitStat(M_EN, M_EN, n);
          e = puv * eff + 2;
          chkRange("R2 power-up delay (R7 tick)", n, e - 1, e + 1);
          rd(3'd0, d); chk("R4 settle progress up", d & M_PR, 32'h1000_0000);
          chk("R3 bl low while settling", {31'd0, backlightEn}, 32'd0);
          chk("R2 vdd high", {31'd0, panelVdd}, 32'd1);
          waitStat(M_PR, 32'h0, n);
          e = stv * eff + 1;
          chkRange("R3 settle delay", n, e - 1, e + 1);
          chk("R3 bl follows control bit", {31'd0, backlightEn}, (bl != 0) ? 32'd1 : 32'd0);
          rd(3'd0, d); chk("R2 enabled when on", d, M_EN);
          wr(3'd1, KEY | bl);
          @(negedge clk);
          chk("R5 bl dropped first", {31'd0, backlightEn}, 32'd0);
          chk("R5 vdd still high", {31'd0, panelVdd}, 32'd1);
          rd(3'd0, d); chk("R4 progress down", d & M_PR, 32'h2000_0000);
          n = 0;
          while (panelVdd && n < 20000) begin n++; @(negedge clk); end
          e = bov * eff + 1;
          chkRange("R5 backlight-off to vdd-off", n, e - 1, e + 1);
          waitStat(M_PR, 32'h0, n);
          e = pdv * eff + 1;
          chkRange("R5 power-down delay", n, e - 1, e + 1);
          waitStat(M_CY, 32'h0, n);
          rd(3'd0, d); chk("R4 back to idle", d, 32'd0);
        end
      end
    end

    // R3 control bit 2 toggled while on
    wr(3'd2, 32'h0001_0001); wr(3'd3, 32'h0001_0001); wr(3'd4, 32'h0000_0100);
    powerUp(BLEN);
    chk("R3 bl on", {31'd0, backlightEn}, 32'd1);
    wr(3'd1, KEY | TGT);
    chk("R3 bl cleared at once", {31'd0, backlightEn}, 32'd0);
    chk("R3 vdd kept", {31'd0, panelVdd}, 32'd1);
    wr(3'd1, KEY | TGT | BLEN);
    chk("R3 bl restored", {31'd0, backlightEn}, 32'd1);
    powerDown(32'd0);

    // R6 power-cycle gap
    for (int k = 0; k < 5; k++) begin
      int f, dv, e;
      f  = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 2 : (k == 3) ? 3 : 2;
      dv = (k == 2 || k == 4) ? 2 : 1;
      wr(3'd4, (32'(dv) << 8) | 32'(f));
      powerUp(32'd0);
      wr(3'd1, KEY);
      waitStat(M_CY, M_CY, n);
      e = ((f > 1) ? (f - 1) * CYCT * dv : 0) + 1;
      if (k == 4) begin
        int bad;
        bad = 0;
        wr(3'd1, KEY | TGT);
        n = 0;
        forever begin
          rd(3'd0, d);
          if ((d & M_CY) == 0) break;
          if (panelVdd) bad++;
          n++;
          if (n >= 20000) break;
          @(negedge clk);
        end
        chkRange("R6 gap with pending target", n, e - 3, e - 1);
        chk("R6 vdd held low during gap", 32'(bad), 32'd0);
        n = 0;
        while (!panelVdd && n < 4) begin n++; @(negedge clk); end
        chkRange("R6 power-up after gap", n, 0, 2);
        powerDown(32'd0);
      end else begin
        n = 0;
        forever begin
          rd(3'd0, d);
          if ((d & M_CY) == 0) break;
          n++;
          if (n >= 20000) break;
          @(negedge clk);
        end
        chkRange("R6 gap length", n, e - 1, e + 1);
      end
    end

    // R9 functional reset
    wr(3'd4, 32'h0000_0102);
    powerUp(PDR | BLEN);
    pulseRst();
    chk("R9 vdd dropped", {31'd0, panelVdd}, 32'd0);
    chk("R9 bl dropped", {31'd0, backlightEn}, 32'd0);
    rd(3'd0, d); chk("R9 cycle armed", d, M_CY);
    rd(3'd1, d); chk("R9 control after reset", d, KEY | PDR);
    waitStat(M_CY, 32'h0, n);
    chkRange("R9 armed gap", n, CYCT - 3, CYCT + 1);
    powerUp(BLEN | OVR);
    pulseRst();
    chk("R9 vdd dropped no pdor", {31'd0, panelVdd}, 32'd0);
    rd(3'd0, d); chk("R9 idle without pdor", d, 32'd0);
    rd(3'd1, d); chk("R9 control no pdor", d, KEY);

    // R10 override
    wr(3'd1, KEY | OVR);
    chk("R10 override raises vdd", {31'd0, panelVdd}, 32'd1);
    rd(3'd0, d); chk("R10 status idle", d, 32'd0);
    wr(3'd1, KEY);
    chk("R10 override cleared", {31'd0, panelVdd}, 32'd0);
    powerUp(32'd0);
    wr(3'd1, KEY);
    waitStat(M_CY, M_CY, n);
    wr(3'd1, KEY | OVR);
    rd(3'd0, d);
    chk("R10 no vdd during gap", {31'd0, panelVdd}, 32'd0);
    chk("R10 gap still running", d & M_CY, M_CY);
    waitStat(M_CY, 32'h0, n);
    chk("R10 vdd after gap", {31'd0, panelVdd}, 32'd1);
    wr(3'd1, KEY);
    chk("R10 vdd off again", {31'd0, panelVdd}, 32'd0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule